// File: doc/BRIEF.md
# Block-Matching Search Cell

This cell is one stage of a linear array for full-search block-matching motion estimation. For one candidate displacement (m, n), it takes an 8x8 block of current-frame pixels x and the matching displaced reference pixels y, one pair per valid cycle. It sums |x - y| over the 64 pairs to get the block's matching cost. A start mark on the first pixel of each candidate clears that sum.

When the 64th pair has been added, the cell compares the finished cost with the best cost handed over by the upstream cell, which is the running minimum of the array. It then passes the smaller cost and its motion vector downstream. Because each stage does this, the search for the minimum is spread along the chain. At the head of the chain, a low qualifier on the incoming minimum means "no minimum yet", and the cell's own cost is taken. The current-frame pixel is registered and forwarded to the next cell together with its valid flag. Frame storage and address generation sit outside the cell.

Top module: `bm_search_cell`

## Requirements
- R1: After reset, `curValidOut`, `resultValid`, `minOut`, `vecOutM` and `vecOutN` are all zero.
- R2: `curValidOut` equals `pixValid` from the previous cycle. On a cycle after a valid pixel, `curPixOut` equals that pixel. After an invalid cycle it keeps its old value.
- R3: The cost of a candidate is the sum of |curPix - refPix| over its 64 valid pixels, treated as 8-bit unsigned values. The count starts at the pixel that carries `candStart`, and `candStart` drops any sum left from before.
- R4: A cycle with `pixValid` low changes neither the cost nor the pixel count, whatever `candStart`, `curPix` and `refPix` carry.
- R5: `resultValid` is high for exactly one cycle, in the cycle right after the clock edge that accepts the 64th valid pixel of a candidate.
- R6: If `minInValid` is low on the 64th pixel, `minOut` becomes the cell's own cost and the output vector becomes its own vector.
- R7: If `minInValid` is high on the 64th pixel, `minOut` becomes the smaller of `minIn` and the own cost. A smaller `minIn` also selects `vecInM`/`vecInN` as the output vector.
- R8: If `minIn` equals the own cost, the incoming value and vector are kept.
- R9: The own vector is (m - 8, n - 8) as 5-bit two's complement. Here m and n are `candM` and `candN` (0 to 16), captured on the pixel that carries `candStart`.
- R10: `minOut`, `vecOutM` and `vecOutN` change only in a cycle where `resultValid` is high.
- R11: A full-scale candidate (every difference 255) gives a cost of 16320 with no wrap in the 14-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Pixel pair on curPix/refPix is valid |
| candStart | input | 1 | First pixel of a new candidate |
| curPix | input | 8 | Current-frame pixel x |
| refPix | input | 8 | Displaced reference pixel y |
| candM | input | 5 | Horizontal displacement index m, 0..16 |
| candN | input | 5 | Vertical displacement index n, 0..16 |
| minInValid | input | 1 | Incoming minimum is meaningful |
| minIn | input | 14 | Best cost from the upstream cell |
| vecInM | input | 5 | Horizontal vector of minIn |
| vecInN | input | 5 | Vertical vector of minIn |
| curPixOut | output | 8 | Registered current pixel for the next cell |
| curValidOut | output | 1 | Registered valid for curPixOut |
| minOut | output | 14 | Best cost passed downstream |
| vecOutM | output | 5 | Horizontal vector of minOut, signed |
| vecOutN | output | 5 | Vertical vector of minOut, signed |
| resultValid | output | 1 | One-cycle mark of a finished compare |

## Verification
The assertions assume that each candidate is framed correctly. `candStart` arrives only on a valid pixel when the pixel count is zero, so a new candidate never cuts into an unfinished one. `candM` and `candN` are assumed to stay within 0..16. The stimulus always sends exactly 64 valid pixels after each start mark and keeps displacements in range. It puts bubbles, with random data and a raised start mark, only between valid pixels, so that the ignored-cycle behaviour is tested without breaking the framing.

// File: rtl/bmsc_pkg.sv
package bmsc_pkg;
  // strobes from the pixel sequencer to the datapath
  typedef struct packed {
    logic accEn;   // accept one difference
    logic clrAcc;  // gate the accumulator feedback to zero
    logic finish;  // this pixel completes the candidate
  } seqStrobe_t;
endpackage

// File: rtl/bmsc_ctrl.sv
module bmsc_ctrl
  import bmsc_pkg::*;
#(
  parameter int BLK = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pixValid,
  input  logic       candStart,
  output seqStrobe_t stb
);
  localparam int NPIX  = BLK * BLK;
  localparam int CNT_W = $clog2(NPIX);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pixIdx;

  assign pixIdx     = candStart ? '0 : cnt;
  assign stb.accEn  = pixValid;
  assign stb.clrAcc = pixValid & candStart;
  assign stb.finish = pixValid && (pixIdx == CNT_W'(NPIX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (pixValid) cnt <= pixIdx + 1'b1;
  end

  // R3: a start mark only arrives at a candidate boundary
  start_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && candStart) |-> (cnt == '0));

  // R4: an invalid cycle leaves the pixel count alone
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pixValid |=> $stable(cnt));
endmodule

// File: rtl/bmsc_dpath.sv
module bmsc_dpath
  import bmsc_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int SRCH  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seqStrobe_t             stb,
  input  logic [PIX_W-1:0]       curPix,
  input  logic [PIX_W-1:0]       refPix,
  input  logic [$clog2(2*SRCH+1)-1:0] candM,
  input  logic [$clog2(2*SRCH+1)-1:0] candN,
  input  logic                   minInValid,
  input  logic [$clog2(BLK*BLK*((1<<PIX_W)-1)+1)-1:0] minIn,
  input  logic [$clog2(2*SRCH+1)-1:0] vecInM,
  input  logic [$clog2(2*SRCH+1)-1:0] vecInN,
  output logic [PIX_W-1:0]       curPixOut,
  output logic                   curValidOut,
  output logic [$clog2(BLK*BLK*((1<<PIX_W)-1)+1)-1:0] minOut,
  output logic [$clog2(2*SRCH+1)-1:0] vecOutM,
  output logic [$clog2(2*SRCH+1)-1:0] vecOutN,
  output logic                   resultValid
);
  localparam int NPIX    = BLK * BLK;
  localparam int ACC_MAX = NPIX * ((1 << PIX_W) - 1);
  localparam int ACC_W   = $clog2(ACC_MAX + 1);
  localparam int DISP_W  = $clog2(2 * SRCH + 1);

  logic [ACC_W-1:0]  acc, accBase, accNext;
  logic [PIX_W-1:0]  absDiff;
  logic [DISP_W-1:0] capM, capN, ownM, ownN;
  logic              takeOwn;

  assign absDiff = (curPix > refPix) ? (curPix - refPix) : (refPix - curPix);
  assign accBase = acc & {ACC_W{~stb.clrAcc}};
  assign accNext = accBase + ACC_W'(absDiff);
  assign ownM    = capM - DISP_W'(SRCH);
  assign ownN    = capN - DISP_W'(SRCH);
  assign takeOwn = !minInValid || (accNext < minIn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      capM <= '0;
      capN <= '0;
    end else begin
      if (stb.accEn) acc <= accNext;
      if (stb.clrAcc) begin
        capM <= candM;
        capN <= candN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      minOut      <= '0;
      vecOutM     <= '0;
      vecOutN     <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= stb.finish;
      if (stb.finish) begin
        minOut  <= takeOwn ? accNext : minIn;
        vecOutM <= takeOwn ? ownM : vecInM;
        vecOutN <= takeOwn ? ownN : vecInN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPixOut   <= '0;
      curValidOut <= 1'b0;
    end else begin
      curValidOut <= stb.accEn;
      if (stb.accEn) curPixOut <= curPix;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= ACC_W'(ACC_MAX));

  // R5
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R10
  hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> ($stable(minOut) && $stable(vecOutM) && $stable(vecOutN)));

  // R7
  never_worse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.finish && minInValid) |=> (minOut <= $past(minIn)));

  // R9
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid && !$past(minInValid) |->
      ($signed(vecOutM) >= -SRCH && $signed(vecOutM) <= SRCH &&
       $signed(vecOutN) >= -SRCH && $signed(vecOutN) <= SRCH));
endmodule

// File: rtl/bm_search_cell.sv
module bm_search_cell
  import bmsc_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int SRCH  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pixValid,
  input  logic                   candStart,
  input  logic [PIX_W-1:0]       curPix,
  input  logic [PIX_W-1:0]       refPix,
  input  logic [$clog2(2*SRCH+1)-1:0] candM,
  input  logic [$clog2(2*SRCH+1)-1:0] candN,
  input  logic                   minInValid,
  input  logic [$clog2(BLK*BLK*((1<<PIX_W)-1)+1)-1:0] minIn,
  input  logic [$clog2(2*SRCH+1)-1:0] vecInM,
  input  logic [$clog2(2*SRCH+1)-1:0] vecInN,
  output logic [PIX_W-1:0]       curPixOut,
  output logic                   curValidOut,
  output logic [$clog2(BLK*BLK*((1<<PIX_W)-1)+1)-1:0] minOut,
  output logic [$clog2(2*SRCH+1)-1:0] vecOutM,
  output logic [$clog2(2*SRCH+1)-1:0] vecOutN,
  output logic                   resultValid
);
  seqStrobe_t stb;

  bmsc_ctrl #(.BLK(BLK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .candStart(candStart), .stb(stb)
  );

  bmsc_dpath #(.PIX_W(PIX_W), .BLK(BLK), .SRCH(SRCH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .curPix(curPix), .refPix(refPix),
    .candM(candM), .candN(candN), .minInValid(minInValid), .minIn(minIn),
    .vecInM(vecInM), .vecInN(vecInN), .curPixOut(curPixOut),
    .curValidOut(curValidOut), .minOut(minOut), .vecOutM(vecOutM),
    .vecOutN(vecOutN), .resultValid(resultValid)
  );
endmodule

// File: tb/tb_bm_search_cell.sv
module tb_bm_search_cell;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pixValid = 0, candStart = 0, minInValid = 0;
  logic [7:0] curPix = 0, refPix = 0, curPixOut;
  logic [4:0] candM = 0, candN = 0, vecInM = 0, vecInN = 0, vecOutM, vecOutN;
  logic [13:0] minIn = 0, minOut;
  logic curValidOut, resultValid;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  int eCurValid = 0, eCurPix = 0, eRes = 0, eMin = 0, eVm = 0, eVn = 0;
  int mAcc = 0, mIdx = 0, mCapM = 0, mCapN = 0;

  bm_search_cell dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2", "curValidOut", int'(curValidOut), eCurValid);
    chk("R2", "curPixOut", int'(curPixOut), eCurPix);
    chk("R5", "resultValid", int'(resultValid), eRes);
    chk("R3 R7 R10", "minOut", int'(minOut), eMin);
    chk("R9 R10", "vecOutM", int'(vecOutM), eVm);
    chk("R9 R10", "vecOutN", int'(vecOutN), eVn);
  endtask

  // drive one cycle, advance the model, then compare after the edge
  task automatic step(input bit v, input bit s, input int x, input int y,
                      input int m, input int n, input int mi, input bit miv,
                      input int vm, input int vn);
    pixValid = v; candStart = s; curPix = 8'(x); refPix = 8'(y);
    candM = 5'(m); candN = 5'(n); minIn = 14'(mi); minInValid = miv;
    vecInM = 5'(vm); vecInN = 5'(vn);
    eCurValid = v;
    eRes = 0;
    if (v) begin
      eCurPix = x;
      if (s) begin mAcc = 0; mIdx = 0; mCapM = m; mCapN = n; end
      mAcc += (x > y) ? x - y : y - x;
      if (mIdx == 63) begin
        eRes = 1;
        if (!miv || mAcc < mi) begin
          eMin = mAcc; eVm = (mCapM - 8) & 31; eVn = (mCapN - 8) & 31;
        end else begin
          eMin = mi; eVm = vm; eVn = vn;
        end
      end
      mIdx = (mIdx + 1) % 64;
    end
    @(negedge clk);
    compareAll();
  endtask

  // pat: 0 random, 1 full scale, 2 identical, 3 reference brighter
  // mode: 0 no incoming min, 1 incoming smaller, 2 tie, 3 incoming larger
  task automatic cand(input int m, input int n, input int pat, input int mode,
                      input int gapEvery, input int vm, input int vn, output int mad);
    int xa[64];
    int ya[64];
    int mi;
    bit miv;
    mad = 0;
    for (int k = 0; k < 64; k++) begin
      case (pat)
        1: begin xa[k] = 255; ya[k] = 0; end
        2: begin xa[k] = $urandom % 256; ya[k] = xa[k]; end
        3: begin xa[k] = $urandom % 128; ya[k] = 128 + ($urandom % 128); end
        default: begin xa[k] = $urandom % 256; ya[k] = $urandom % 256; end
      endcase
      mad += (xa[k] > ya[k]) ? xa[k] - ya[k] : ya[k] - xa[k];
    end
    miv = (mode != 0);
    case (mode)
      1: mi = mad - 1;
      2: mi = mad;
      3: mi = mad + 1;
      default: mi = 16383;
    endcase
    for (int k = 0; k < 64; k++) begin
      if (gapEvery > 0 && k > 0 && (k % gapEvery) == 0)
        step(0, 1, $urandom % 256, $urandom % 256, 3, 3, mi, miv, vm, vn); // R4 bubble
      step(1, k == 0, xa[k], ya[k], m, n, mi, miv, vm, vn);
    end
  endtask

  task automatic idle(input int cycles);
    for (int k = 0; k < cycles; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int mad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "resetState", int'({curValidOut, resultValid, minOut, vecOutM, vecOutN}), 0);
    compareAll();

    cand(12, 3, 0, 0, 0, 0, 0, mad);      // R6 chain head takes own cost, R9 vector
    idle(3);                              // R10 hold
    chk("R6", "ownCost", int'(minOut), mad);
    chk("R9", "vecM", int'(vecOutM), 4);
    chk("R9", "vecN", int'(vecOutN), 27);

    cand(5, 9, 0, 1, 0, 7, 25, mad);      // R7 incoming smaller wins
    idle(2);
    chk("R7", "incomingVec", int'(vecOutM), 7);

    cand(16, 0, 0, 3, 0, 2, 2, mad);      // R7 own smaller wins, R9 extremes
    idle(1);
    chk("R9", "vecMplus8", int'(vecOutM), 8);
    chk("R9", "vecNminus8", int'(vecOutN), 24);

    cand(0, 16, 3, 2, 0, 11, 13, mad);    // R8 tie keeps incoming
    idle(1);
    chk("R8", "tieVecM", int'(vecOutM), 11);
    chk("R8", "tieMin", int'(minOut), mad);

    cand(8, 8, 1, 0, 0, 0, 0, mad);       // R11 full scale
    idle(1);
    chk("R11", "fullScale", int'(minOut), 16320);

    cand(2, 14, 0, 0, 5, 0, 0, mad);      // R4 bubbles with stray start marks
    idle(1);
    chk("R4", "bubbleCost", int'(minOut), mad);

    cand(8, 8, 2, 0, 0, 0, 0, mad);       // R3 zero cost, back to back next
    cand(1, 1, 0, 0, 3, 0, 0, mad);       // R3 accumulator cleared
    cand(9, 6, 1, 3, 0, 4, 4, mad);       // R7 incoming larger than full scale
    idle(4);
    chk("R3", "lastCost", int'(minOut), 16320);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule